// File: doc/BRIEF.md
# Timer Channel Interrupt Router

This block sits behind the comparator of one timer channel and turns each fire strobe into the interrupt that the channel's configuration word asks for. Depending on that word, a strobe produces nothing, a one-cycle pulse command on an interrupt-controller pin, a level assertion on that pin, or a message request that carries an address/data pair. For a level interrupt the block keeps the channel's status bit set until software clears it, and it drops the pin when that happens.

The block also holds the configuration word. Masked writes update the writable fields. The capability fields are read-only. A route that selects a pin outside the allowed-pin mask is replaced by "not connected". When a configuration change would leave a level interrupt asserted with nobody responsible for it, the block clears the status bit and issues a deassert command for the pin that had been driven. The allowed-pin mask comes from the size of the interrupt controller, which is a parameter.

Top module: `tmr_irq_router`

## Requirements
- R1: After reset the configuration reads as the allowed-pin mask in bits 63:32 with bit 4 (periodic capable) and bit 15 (message capable) set. The status is 0 and all command outputs are 0. Pin selects, message address and message data read 0 whenever their strobe is low. With the default 24-pin controller the mask is 0x00F00000 (pins 20 to 23). A 32-pin controller gives 0xFF000000, 20 to 31 pins give the top four pins, and fewer than 20 pins give 0.
- R2: A masked write keeps bits 63:32, bit 4, bit 5 (64-bit capable) and bit 15 at their previous values, and bit 8 (32-bit mode) always reads 0. Every other bit takes the written data where the mask bit is 1.
- R3: The route field is bits 13:9. If a write leaves it nonzero and selecting a pin whose bit is 0 in configuration bits 63:32, the field is forced to 0.
- R4: A fire strobe delivers nothing while bit 2 (interrupt enable) is 0.
- R5: With enable set, message mode off and bit 1 = 0 (edge), a fire strobe with a nonzero route gives a one-cycle pin_pulse_o with pin_sel_o equal to the route, and the status stays 0.
- R6: With bit 1 = 1 (level), a fire strobe sets the status and gives a one-cycle pin_assert_o with pin_sel_o equal to the route. Further strobes deliver nothing while the status is set.
- R7: With message mode off, a route of 0 means no pin, and a fire strobe delivers nothing.
- R8: Message mode is on when bit 15 and bit 14 are both set. In that mode the channel has no pin route, and a fire strobe gives a one-cycle msg_req_o with msg_addr_o equal to bits 63:32 and msg_data_o equal to bits 31:0 of msg_route_i.
- R9: A status-clear strobe while the status is set clears it and issues pin_deassert_o with drop_sel_o equal to the driven pin. While the status is 0 it does nothing.
- R10: While the status is set, a configuration write that clears the enable, turns message mode on, switches to edge, or changes the route clears the status and issues pin_deassert_o with drop_sel_o equal to the previous pin.
- R11: A write that leaves the configuration value unchanged has no effect on any output.
- R12: When a write and a fire strobe arrive in the same cycle, the strobe is handled under the configuration after the write. Every result appears on the outputs one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fire_i | input | 1 | Comparator match strobe |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_wdata_i | input | 64 | Configuration write data |
| cfg_wmask_i | input | 64 | Per-bit write enable |
| stat_clr_i | input | 1 | Software status clear strobe |
| msg_route_i | input | 64 | Message address (63:32) and data (31:0) |
| cfg_o | output | 64 | Current configuration word |
| stat_o | output | 1 | Channel interrupt status bit |
| pin_sel_o | output | 5 | Pin for assert or pulse command |
| pin_assert_o | output | 1 | Level assert command |
| pin_pulse_o | output | 1 | Edge pulse command |
| drop_sel_o | output | 5 | Pin for deassert command |
| pin_deassert_o | output | 1 | Level deassert command |
| msg_req_o | output | 1 | Message request |
| msg_addr_o | output | 32 | Message address |
| msg_data_o | output | 32 | Message data |

## Verification
The hardest situation to reach is the automatic release of a held level interrupt. It needs the status bit set first, which takes a level-mode setup followed by a fire strobe, and only then a configuration write that changes exactly one of the four triggering properties. The stimulus rebuilds the level state before each of the four writes so that every cause is seen on its own with the expected old pin. Writes that change nothing, and writes whose fire strobe falls in the same cycle, are placed next to these to show they neither release nor double-assert.

// File: rtl/tmr_irq_pkg.sv
`timescale 1ns/1ps
package tmr_irq_pkg;
    localparam int CFG_W     = 64;
    localparam int HALF_W    = CFG_W / 2;
    localparam int ROUTE_LSB = 9;
    localparam int ROUTE_W   = 5;
    localparam int ROUTE_MSB = ROUTE_LSB + ROUTE_W - 1;
    localparam int NUM_PINS  = 1 << ROUTE_W;

    // configuration bit positions
    localparam int B_LEVEL  = 1;
    localparam int B_IEN    = 2;
    localparam int B_PERCAP = 4;
    localparam int B_WIDE   = 5;
    localparam int B_M32    = 8;
    localparam int B_MSGEN  = 14;
    localparam int B_MSGCAP = 15;

    localparam logic [CFG_W-1:0] RO_BITS =
        {{HALF_W{1'b1}}, {HALF_W{1'b0}}}
        | (CFG_W'(1) << B_PERCAP) | (CFG_W'(1) << B_WIDE) | (CFG_W'(1) << B_MSGCAP);
    localparam logic [CFG_W-1:0] FORCE_ZERO = CFG_W'(1) << B_M32;

    function automatic logic [HALF_W-1:0] allowed_pins(input int pin_count);
        if (pin_count >= 32)      return 32'hFF00_0000;
        else if (pin_count >= 20) return 32'hF << (pin_count - 4);
        else                      return '0;
    endfunction

    typedef struct packed {
        logic [CFG_W-1:0]   cfg;
        logic               stat;
        logic               pulse;
        logic               asrt;
        logic               deas;
        logic [ROUTE_W-1:0] psel;
        logic [ROUTE_W-1:0] dsel;
        logic               mreq;
        logic [HALF_W-1:0]  maddr;
        logic [HALF_W-1:0]  mdata;
    } irq_state_t;
endpackage

// File: rtl/tmr_irq_route_dec.sv
`timescale 1ns/1ps
module tmr_irq_route_dec
    import tmr_irq_pkg::*;
(
    input  logic [CFG_W-1:0]   cfg,
    output logic [ROUTE_W-1:0] pin,
    output logic               msg_on,
    output logic               ien,
    output logic               level
);
    always_comb begin
        msg_on = cfg[B_MSGCAP] & cfg[B_MSGEN];
        pin    = msg_on ? '0 : cfg[ROUTE_MSB:ROUTE_LSB];
        ien    = cfg[B_IEN];
        level  = cfg[B_LEVEL];
    end
endmodule

// File: rtl/tmr_irq_cfg_upd.sv
`timescale 1ns/1ps
module tmr_irq_cfg_upd
    import tmr_irq_pkg::*;
(
    input  logic [CFG_W-1:0]   cur_cfg,
    input  logic               wr_en,
    input  logic [CFG_W-1:0]   wr_data,
    input  logic [CFG_W-1:0]   wr_mask,
    output logic [CFG_W-1:0]   nxt_cfg,
    output logic [ROUTE_W-1:0] cur_pin,
    output logic               drop_level
);
    logic [CFG_W-1:0]   merged;
    logic [CFG_W-1:0]   cand;
    logic [ROUTE_W-1:0] raw_route;
    logic [HALF_W-1:0]  allow;
    logic               changed;
    logic               c_msg, c_ien, c_lvl;
    logic [ROUTE_W-1:0] n_pin;
    logic               n_msg, n_ien, n_lvl;

    always_comb begin
        merged    = (cur_cfg & ~wr_mask) | (wr_data & wr_mask);
        merged    = (merged & ~(RO_BITS | FORCE_ZERO)) | (cur_cfg & RO_BITS);
        allow     = merged[CFG_W-1:HALF_W];
        raw_route = merged[ROUTE_MSB:ROUTE_LSB];
        cand      = merged;
        if (raw_route != '0 && !allow[raw_route])
            cand[ROUTE_MSB:ROUTE_LSB] = '0;
        changed   = wr_en && (cand != cur_cfg);
        nxt_cfg   = changed ? cand : cur_cfg;
    end

    tmr_irq_route_dec u_cur (.cfg(cur_cfg), .pin(cur_pin), .msg_on(c_msg), .ien(c_ien), .level(c_lvl));
    tmr_irq_route_dec u_nxt (.cfg(nxt_cfg), .pin(n_pin),   .msg_on(n_msg), .ien(n_ien), .level(n_lvl));

    // a held level can only exist under a level, enabled, pin-routed config
    always_comb begin
        drop_level = changed && c_ien && c_lvl && !c_msg &&
                     (!n_ien || n_msg || !n_lvl || (n_pin != cur_pin));
    end
endmodule

// File: rtl/tmr_irq_deliver.sv
`timescale 1ns/1ps
module tmr_irq_deliver
    import tmr_irq_pkg::*;
(
    input  logic               fire,
    input  logic [CFG_W-1:0]   cfg,
    input  logic               stat_now,
    input  logic [CFG_W-1:0]   msg_route,
    output logic               pulse,
    output logic               asrt,
    output logic [ROUTE_W-1:0] psel,
    output logic               mreq,
    output logic [HALF_W-1:0]  maddr,
    output logic [HALF_W-1:0]  mdata
);
    logic [ROUTE_W-1:0] pin;
    logic               msg_on, ien, level, go;

    tmr_irq_route_dec u_dec (.cfg(cfg), .pin(pin), .msg_on(msg_on), .ien(ien), .level(level));

    always_comb begin
        pulse = 1'b0;
        asrt  = 1'b0;
        psel  = '0;
        mreq  = 1'b0;
        maddr = '0;
        mdata = '0;
        go    = fire && ien && !stat_now;
        if (go) begin
            if (msg_on) begin
                mreq  = 1'b1;
                maddr = msg_route[CFG_W-1:HALF_W];
                mdata = msg_route[HALF_W-1:0];
            end else if (pin != '0) begin
                psel  = pin;
                pulse = !level;
                asrt  = level;
            end
        end
    end
endmodule

// File: rtl/tmr_irq_router.sv
`timescale 1ns/1ps
module tmr_irq_router
    import tmr_irq_pkg::*;
#(
    parameter int PIN_COUNT = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               fire_i,
    input  logic               cfg_wr_i,
    input  logic [63:0]        cfg_wdata_i,
    input  logic [63:0]        cfg_wmask_i,
    input  logic               stat_clr_i,
    input  logic [63:0]        msg_route_i,
    output logic [63:0]        cfg_o,
    output logic               stat_o,
    output logic [4:0]         pin_sel_o,
    output logic               pin_assert_o,
    output logic               pin_pulse_o,
    output logic [4:0]         drop_sel_o,
    output logic               pin_deassert_o,
    output logic               msg_req_o,
    output logic [31:0]        msg_addr_o,
    output logic [31:0]        msg_data_o
);
    localparam logic [HALF_W-1:0] ALLOW = allowed_pins(PIN_COUNT);
    localparam logic [CFG_W-1:0]  CFG_RST = {ALLOW, {HALF_W{1'b0}}}
        | (CFG_W'(1) << B_PERCAP) | (CFG_W'(1) << B_MSGCAP);

    irq_state_t         st_d, st_q;
    logic [CFG_W-1:0]   upd_cfg;
    logic [ROUTE_W-1:0] cur_pin;
    logic               drop_level;
    logic               stat_mid;
    logic               dv_pulse, dv_asrt, dv_mreq;
    logic [ROUTE_W-1:0] dv_psel;
    logic [HALF_W-1:0]  dv_addr, dv_data;

    tmr_irq_cfg_upd u_upd (
        .cur_cfg    (st_q.cfg),
        .wr_en      (cfg_wr_i),
        .wr_data    (cfg_wdata_i),
        .wr_mask    (cfg_wmask_i),
        .nxt_cfg    (upd_cfg),
        .cur_pin    (cur_pin),
        .drop_level (drop_level)
    );

    tmr_irq_deliver u_dlv (
        .fire      (fire_i),
        .cfg       (upd_cfg),
        .stat_now  (stat_mid),
        .msg_route (msg_route_i),
        .pulse     (dv_pulse),
        .asrt      (dv_asrt),
        .psel      (dv_psel),
        .mreq      (dv_mreq),
        .maddr     (dv_addr),
        .mdata     (dv_data)
    );

    always_comb begin
        st_d      = '0;
        st_d.cfg  = upd_cfg;
        stat_mid  = st_q.stat;
        if (st_q.stat && (drop_level || stat_clr_i)) begin
            stat_mid  = 1'b0;
            st_d.deas = 1'b1;
            st_d.dsel = cur_pin;
        end
        st_d.stat  = stat_mid | dv_asrt;
        st_d.pulse = dv_pulse;
        st_d.asrt  = dv_asrt;
        st_d.psel  = dv_psel;
        st_d.mreq  = dv_mreq;
        st_d.maddr = dv_addr;
        st_d.mdata = dv_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.cfg <= CFG_RST;
        end else begin
            st_q <= st_d;
        end
    end

    assign cfg_o          = st_q.cfg;
    assign stat_o         = st_q.stat;
    assign pin_sel_o      = st_q.psel;
    assign pin_assert_o   = st_q.asrt;
    assign pin_pulse_o    = st_q.pulse;
    assign drop_sel_o     = st_q.dsel;
    assign pin_deassert_o = st_q.deas;
    assign msg_req_o      = st_q.mreq;
    assign msg_addr_o     = st_q.maddr;
    assign msg_data_o     = st_q.mdata;
endmodule

// File: rtl/tmr_irq_router_chk.sv
`timescale 1ns/1ps
module tmr_irq_router_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [63:0] cfg_o,
    input logic        stat_o,
    input logic        pin_assert_o,
    input logic        pin_pulse_o,
    input logic        pin_deassert_o,
    input logic        msg_req_o
);
    logic [4:0] route;
    assign route = cfg_o[13:9];

    // R2: read-only fields never move, 32-bit mode reads zero
    a_r2_ro_fields: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ($stable(cfg_o[63:32]) && $stable(cfg_o[4]) && $stable(cfg_o[5])
                  && $stable(cfg_o[15]) && !cfg_o[8]));

    // R3: a nonzero route always names an allowed pin
    a_r3_route_allowed: assert property (@(posedge clk) disable iff (!rst_n)
        (route != 5'd0) |-> cfg_o[32 + route]);

    // R4: every delivery happens under an enabled configuration
    a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pulse_o || pin_assert_o || msg_req_o) |-> cfg_o[2]);

    // R5: an edge pulse leaves no status behind
    a_r5_pulse_no_status: assert property (@(posedge clk) disable iff (!rst_n)
        pin_pulse_o |-> !stat_o);

    // R6: a level assertion is always recorded in the status
    a_r6_level_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
        pin_assert_o |-> stat_o);

    // R6: no second assertion while the status was already held
    a_r6_no_double: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stat_o) && !pin_deassert_o) |-> !pin_assert_o);

    // R8: message delivery excludes pin commands
    a_r8_msg_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        msg_req_o |-> (!pin_pulse_o && !pin_assert_o));

    // R9: a deassert only follows a held status
    a_r9_deassert_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
        pin_deassert_o |-> $past(stat_o));
endmodule

bind tmr_irq_router tmr_irq_router_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_o          (cfg_o),
    .stat_o         (stat_o),
    .pin_assert_o   (pin_assert_o),
    .pin_pulse_o    (pin_pulse_o),
    .pin_deassert_o (pin_deassert_o),
    .msg_req_o      (msg_req_o)
);

// File: tb/tmr_irq_router_tb.sv
`timescale 1ns/1ps
module tmr_irq_router_tb;
    localparam logic [31:0] MASK_HI = 32'h00F0_0000;
    localparam logic [63:0] ALL     = 64'hFFFF_FFFF_FFFF_FFFF;
    localparam logic [63:0] MROUTE  = 64'h1234_5678_9ABC_DEF0;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fire_i = 1'b0, cfg_wr_i = 1'b0, stat_clr_i = 1'b0;
    logic [63:0] cfg_wdata_i = '0, cfg_wmask_i = '0, msg_route_i = MROUTE;
    logic [63:0] cfg_o;
    logic        stat_o, pin_assert_o, pin_pulse_o, pin_deassert_o, msg_req_o;
    logic [4:0]  pin_sel_o, drop_sel_o;
    logic [31:0] msg_addr_o, msg_data_o;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        string        tag;
        logic [142:0] val;
    } exp_t;
    exp_t sb[$];

    always #10 clk = ~clk;

    tmr_irq_router u_dut (
        .clk(clk), .rst_n(rst_n), .fire_i(fire_i), .cfg_wr_i(cfg_wr_i),
        .cfg_wdata_i(cfg_wdata_i), .cfg_wmask_i(cfg_wmask_i), .stat_clr_i(stat_clr_i),
        .msg_route_i(msg_route_i), .cfg_o(cfg_o), .stat_o(stat_o), .pin_sel_o(pin_sel_o),
        .pin_assert_o(pin_assert_o), .pin_pulse_o(pin_pulse_o), .drop_sel_o(drop_sel_o),
        .pin_deassert_o(pin_deassert_o), .msg_req_o(msg_req_o),
        .msg_addr_o(msg_addr_o), .msg_data_o(msg_data_o)
    );

    // driver: apply one cycle of stimulus, push the expected result
    task automatic step(input string tag, input bit fire, input bit wr,
                        input logic [63:0] wd, input logic [63:0] wm, input bit clr,
                        input logic [31:0] cfg_lo, input bit stat, input bit pulse,
                        input bit asrt, input bit deas, input logic [4:0] psel,
                        input logic [4:0] dsel, input bit mreq,
                        input logic [31:0] maddr, input logic [31:0] mdata);
        exp_t e;
        @(negedge clk);
        fire_i      = fire;
        cfg_wr_i    = wr;
        cfg_wdata_i = wd;
        cfg_wmask_i = wm;
        stat_clr_i  = clr;
        e.tag = tag;
        e.val = {MASK_HI, cfg_lo, stat, pulse, asrt, deas, psel, dsel, mreq, maddr, mdata};
        sb.push_back(e);
    endtask

    task automatic wr(input string tag, input logic [31:0] wd, input logic [31:0] cfg_lo,
                      input bit stat, input bit deas, input logic [4:0] dsel);
        step(tag, 0, 1, {32'h0, wd}, ALL, 0, cfg_lo, stat, 0, 0, deas, 5'd0, dsel, 0, 0, 0);
    endtask

    // monitor: sample 5 ns after the rising edge and compare
    initial begin
        forever begin
            @(posedge clk);
            #5;
            if (sb.size() > 0) begin
                exp_t e;
                logic [142:0] act;
                e   = sb.pop_front();
                act = {cfg_o, stat_o, pin_pulse_o, pin_assert_o, pin_deassert_o,
                       pin_sel_o, drop_sel_o, msg_req_o, msg_addr_o, msg_data_o};
                checks++;
                if (act !== e.val) begin
                    errors++;
                    $display("FAIL %s: actual=%h expected=%h", e.tag, act, e.val);
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R1 reset state
        step("R1 reset", 0, 0, 0, 0, 0, 32'h8010, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        // R2 and R3: all ones, route 31 not allowed
        step("R2/R3 ro fields", 0, 1, ALL, ALL, 0, 32'hFFFF_C0DF, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        wr("R5 setup edge pin20", 32'h2804, 32'hA814, 0, 0, 0);
        step("R5 edge pulse", 1, 0, 0, 0, 0, 32'hA814, 0, 1, 0, 0, 5'd20, 0, 0, 0, 0);
        wr("R3 route5 rejected", 32'h0A04, 32'h8014, 0, 0, 0);
        step("R7 no route", 1, 0, 0, 0, 0, 32'h8014, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        wr("R4 setup disabled", 32'h2800, 32'hA810, 0, 0, 0);
        step("R4 disabled fire", 1, 0, 0, 0, 0, 32'hA810, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        wr("R6 setup level", 32'h2806, 32'hA816, 0, 0, 0);
        step("R6 level assert", 1, 0, 0, 0, 0, 32'hA816, 1, 0, 1, 0, 5'd20, 0, 0, 0, 0);
        step("R6 held no repeat", 1, 0, 0, 0, 0, 32'hA816, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        wr("R11 same value", 32'h2806, 32'hA816, 1, 0, 0);
        step("R11 zero mask", 0, 1, ALL, 64'h0, 0, 32'hA816, 1, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R9 status clear", 0, 0, 0, 0, 1, 32'hA816, 0, 0, 0, 1, 0, 5'd20, 0, 0, 0);
        step("R9 clear idle", 0, 0, 0, 0, 1, 32'hA816, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R6 reassert", 1, 0, 0, 0, 0, 32'hA816, 1, 0, 1, 0, 5'd20, 0, 0, 0, 0);
        wr("R10 to edge", 32'h2804, 32'hA814, 0, 1, 5'd20);
        wr("R10 back level", 32'h2806, 32'hA816, 0, 0, 0);
        step("R6 assert b", 1, 0, 0, 0, 0, 32'hA816, 1, 0, 1, 0, 5'd20, 0, 0, 0, 0);
        wr("R10 disable", 32'h2802, 32'hA812, 0, 1, 5'd20);
        wr("R10 reenable", 32'h2806, 32'hA816, 0, 0, 0);
        step("R6 assert c", 1, 0, 0, 0, 0, 32'hA816, 1, 0, 1, 0, 5'd20, 0, 0, 0, 0);
        wr("R10 reroute", 32'h2A06, 32'hAA16, 0, 1, 5'd20);
        step("R6 assert pin21", 1, 0, 0, 0, 0, 32'hAA16, 1, 0, 1, 0, 5'd21, 0, 0, 0, 0);
        wr("R10 message on", 32'h6A06, 32'hEA16, 0, 1, 5'd21);
        step("R8 message", 1, 0, 0, 0, 0, 32'hEA16, 0, 0, 0, 0, 0, 0, 1,
             MROUTE[63:32], MROUTE[31:0]);
        step("R12 write+fire edge", 1, 1, 64'h2A04, ALL, 0, 32'hAA14, 0, 1, 0, 0, 5'd21, 0, 0, 0, 0);
        step("R12 write+fire off", 1, 1, 64'h2A00, ALL, 0, 32'hAA10, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        step("R1 idle end", 0, 0, 0, 0, 0, 32'hAA10, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        @(negedge clk);
        fire_i = 0; cfg_wr_i = 0; stat_clr_i = 0;
        while (sb.size() > 0) @(posedge clk);
        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule